// File: doc/BRIEF.md
# Filtered Event Performance Counter

This block counts events for performance monitoring. Each cycle, an upstream event-selection stage presents a small event count. The counter can add that count as it stands. It can instead pass the count through a threshold filter. The filter can invert its comparison and can count only the cycles in which the comparison first turns true. The result accumulates in a 40-bit counter. To get an interrupt after N events, software first loads the counter with the two's-complement negative of N. The counter then climbs to all ones, and the next increment carries out of the top bit. That carry sets a sticky overflow flag and raises an interrupt request.

Software reaches the block through a single register port. One select bit chooses either the control word or the counter, for writes and for reads. The control word holds these fields:

- an enable;
- a three-bit source tag that the upstream selector decodes;
- the filter mode bits and the threshold;
- the overflow status.

The edge detector is a three-state machine:

- `EG_OFF`: the counter is disabled.
- `EG_LOW`: the last enabled cycle's comparison was false.
- `EG_HIGH`: the last enabled cycle's comparison was true.

The machine has these transitions:

- `go_off`: any state moves to `EG_OFF` while the enable is clear.
- `see_low`: an enabled cycle whose comparison is false moves to `EG_LOW`.
- `see_high`: an enabled cycle whose comparison is true moves to `EG_HIGH`.

Reset places the machine in `EG_OFF`. A rising edge is a true comparison in any state other than `EG_HIGH`.

Top module: `evtctr_top`

## Requirements
- R1: After reset, the counter reads 0, the control word reads 0 and `ovf_irq` is low.
- R2: Control bit 12 enables counting. While it is 0, the counter keeps its value whatever `evt_cnt` is. A control write takes effect from the next cycle.
- R3: With compare (control bit 18) clear, each enabled cycle adds `evt_cnt` unchanged. Complement (bit 19) and edge (bit 24) have no effect in this mode.
- R4: With compare set and complement clear, each enabled cycle adds 1 when `evt_cnt` is greater than the threshold in control bits 20-23, and adds 0 otherwise.
- R5: With compare set and complement set, each enabled cycle adds 1 when `evt_cnt` is less than or equal to the threshold, and adds 0 otherwise.
- R6: With compare and edge both set, 1 is added only in an enabled cycle whose comparison is true after a cycle where it was false. The remembered previous result is false after reset and after any disabled cycle.
- R7: A write with `wr_sel`=1 loads all 40 counter bits. It takes priority over an increment in the same cycle.
- R8: A carry out of bit 39 wraps the counter to the low 40 bits of the sum. It also sets the sticky overflow flag (control bit 31) and `ovf_irq`, and both stay high.
- R9: A control write with bit 31 set clears the overflow flag. If an overflow occurs in that same cycle, the flag stays set.
- R10: The source tag in control bits 13-15 reads back as written. Reserved control bits (0-11, 16-17, 25-30) read as 0.
- R11: With `rd_sel`=0, `rd_data` shows the control word, zero-extended. With `rd_sel`=1, it shows the counter. The read path is combinational.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 control, 1 counter |
| wr_data | input | 40 | Write data |
| rd_sel | input | 1 | Read target: 0 control, 1 counter |
| rd_data | output | 40 | Read data |
| evt_cnt | input | 4 | Event count for this cycle |
| ovf_irq | output | 1 | Overflow interrupt request |

## Verification
Two pairs of functions can land in the same cycle.

- **Counter write and increment.** The bench issues a counter write while a nonzero event is applied to an enabled counter. The check passes only if the written value is read back, with no event added.
- **Overflow and flag clear.** The bench presets the counter to all ones, then issues a control write carrying the clear bit while a one-count event is applied. The check requires the interrupt and status flag to remain high and the counter to wrap to 0.

// File: rtl/evtctr_pkg.sv
package evtctr_pkg;

    localparam int CTL_W  = 32;
    localparam int THR_W  = 4;
    localparam int SRC_W  = 3;

    localparam int EN_B   = 12;
    localparam int SRC_LO = 13;
    localparam int CMP_B  = 18;
    localparam int CPL_B  = 19;
    localparam int THR_LO = 20;
    localparam int EDG_B  = 24;
    localparam int OVF_B  = 31;

    localparam logic SEL_CTL = 1'b0;
    localparam logic SEL_CNT = 1'b1;

    typedef struct packed {
        logic             edge_on;
        logic [THR_W-1:0] thr;
        logic             cpl;
        logic             cmp;
        logic [SRC_W-1:0] src;
        logic             en;
    } ctl_t;

    typedef enum logic [1:0] {
        EG_OFF  = 2'd0,
        EG_LOW  = 2'd1,
        EG_HIGH = 2'd2
    } eg_st_t;

endpackage

// File: rtl/evtctr_ctl.sv
module evtctr_ctl
    import evtctr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_ctl,
    input  ctl_t             wr_cfg,
    input  logic             wr_clr,
    input  logic             ovf_set,
    output ctl_t             cfg,
    output logic             ovf_flag,
    output logic [CTL_W-1:0] ctl_word
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg <= '0;
        end else if (wr_ctl) begin
            cfg <= wr_cfg;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ovf_flag <= 1'b0;
        end else if (ovf_set) begin
            ovf_flag <= 1'b1;
        end else if (wr_ctl && wr_clr) begin
            ovf_flag <= 1'b0;
        end
    end

    always_comb begin
        ctl_word                       = '0;
        ctl_word[EN_B]                 = cfg.en;
        ctl_word[SRC_LO +: SRC_W]      = cfg.src;
        ctl_word[CMP_B]                = cfg.cmp;
        ctl_word[CPL_B]                = cfg.cpl;
        ctl_word[THR_LO +: THR_W]      = cfg.thr;
        ctl_word[EDG_B]                = cfg.edge_on;
        ctl_word[OVF_B]                = ovf_flag;
    end

    // R8
    sticky_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_set |=> ovf_flag);

    // R8
    sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_flag && !(wr_ctl && wr_clr)) |=> ovf_flag);

    // R9
    clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctl && wr_clr && !ovf_set) |=> !ovf_flag);

endmodule

// File: rtl/evtctr_filt.sv
module evtctr_filt
    import evtctr_pkg::*;
#(
    parameter int EVT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             cmp,
    input  logic             cpl,
    input  logic             edge_on,
    input  logic [THR_W-1:0] thr,
    input  logic [EVT_W-1:0] evt,
    output logic [EVT_W-1:0] inc
);

    localparam int CMP_W = (EVT_W > THR_W) ? EVT_W : THR_W;

    eg_st_t     st_q, st_d;
    logic [CMP_W-1:0] evt_x, thr_x;
    logic       cmp_true;
    logic       prev_hi;
    logic       rise;

    assign evt_x    = CMP_W'(evt);
    assign thr_x    = CMP_W'(thr);
    assign cmp_true = cpl ? (evt_x <= thr_x) : (evt_x > thr_x);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= EG_OFF;
        end else begin
            st_q <= st_d;
        end
    end

    // transitions: go_off, see_high, see_low
    always_comb begin
        if (!en) begin
            st_d = EG_OFF;
        end else if (cmp_true) begin
            st_d = EG_HIGH;
        end else begin
            st_d = EG_LOW;
        end
    end

    // outputs
    always_comb begin
        unique case (st_q)
            EG_HIGH: prev_hi = 1'b1;
            EG_LOW:  prev_hi = 1'b0;
            EG_OFF:  prev_hi = 1'b0;
            default: prev_hi = 1'b0;
        endcase
        rise = cmp_true && !prev_hi;
        if (!en) begin
            inc = '0;
        end else if (!cmp) begin
            inc = evt;
        end else if (edge_on) begin
            inc = EVT_W'(rise);
        end else begin
            inc = EVT_W'(cmp_true);
        end
    end

    // R4 R5
    filt_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && cmp) |-> (inc <= EVT_W'(1)));

    // R6
    edge_rpt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && cmp && edge_on && $past(en) && $past(cmp_true)) |-> (inc == '0));

    // R2
    off_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |-> (inc == '0));

endmodule

// File: rtl/evtctr_cnt.sv
module evtctr_cnt #(
    parameter int CTR_W = 40,
    parameter int INC_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ld,
    input  logic [CTR_W-1:0] ld_val,
    input  logic             en,
    input  logic [INC_W-1:0] inc,
    output logic [CTR_W-1:0] cnt,
    output logic             ovf_pulse
);

    logic [CTR_W:0] sum;

    assign sum       = {1'b0, cnt} + (CTR_W+1)'(inc);
    assign ovf_pulse = en && !ld && sum[CTR_W];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (ld) begin
            cnt <= ld_val;
        end else if (en) begin
            cnt <= sum[CTR_W-1:0];
        end
    end

    // R7
    ctr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ld |=> (cnt == $past(ld_val)));

    // R2
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !ld) |=> $stable(cnt));

    // R8
    wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_pulse |=> (cnt < CTR_W'(2**INC_W)));

endmodule

// File: rtl/evtctr_top.sv
module evtctr_top
    import evtctr_pkg::*;
#(
    parameter int CTR_W = 40,
    parameter int EVT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             wr_sel,
    input  logic [CTR_W-1:0] wr_data,
    input  logic             rd_sel,
    output logic [CTR_W-1:0] rd_data,
    input  logic [EVT_W-1:0] evt_cnt,
    output logic             ovf_irq
);

    ctl_t             cfg;
    ctl_t             wr_cfg;
    logic             wr_ctl, wr_cnt;
    logic             ovf_pulse, ovf_flag;
    logic [CTL_W-1:0] ctl_word;
    logic [EVT_W-1:0] inc;
    logic [CTR_W-1:0] cnt;

    assign wr_ctl = wr_en && (wr_sel == SEL_CTL);
    assign wr_cnt = wr_en && (wr_sel == SEL_CNT);

    assign wr_cfg.en      = wr_data[EN_B];
    assign wr_cfg.src     = wr_data[SRC_LO +: SRC_W];
    assign wr_cfg.cmp     = wr_data[CMP_B];
    assign wr_cfg.cpl     = wr_data[CPL_B];
    assign wr_cfg.thr     = wr_data[THR_LO +: THR_W];
    assign wr_cfg.edge_on = wr_data[EDG_B];

    evtctr_ctl u_ctl (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_ctl   (wr_ctl),
        .wr_cfg   (wr_cfg),
        .wr_clr   (wr_data[OVF_B]),
        .ovf_set  (ovf_pulse),
        .cfg      (cfg),
        .ovf_flag (ovf_flag),
        .ctl_word (ctl_word)
    );

    evtctr_filt #(.EVT_W(EVT_W)) u_filt (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (cfg.en),
        .cmp     (cfg.cmp),
        .cpl     (cfg.cpl),
        .edge_on (cfg.edge_on),
        .thr     (cfg.thr),
        .evt     (evt_cnt),
        .inc     (inc)
    );

    evtctr_cnt #(.CTR_W(CTR_W), .INC_W(EVT_W)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .ld        (wr_cnt),
        .ld_val    (wr_data),
        .en        (cfg.en),
        .inc       (inc),
        .cnt       (cnt),
        .ovf_pulse (ovf_pulse)
    );

    assign rd_data = (rd_sel == SEL_CNT) ? cnt : CTR_W'(ctl_word);
    assign ovf_irq = ovf_flag;

    // R8
    irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf_irq) |-> $past(ovf_pulse));

endmodule

// File: tb/sim_evtctr_top.sv
module sim_evtctr_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        wr_sel = 1'b0;
    logic [39:0] wr_data = '0;
    logic        rd_sel = 1'b0;
    logic [39:0] rd_data;
    logic [3:0]  evt_cnt = '0;
    logic        ovf_irq;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    evtctr_top u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data),
        .evt_cnt(evt_cnt), .ovf_irq(ovf_irq)
    );

    function automatic logic [39:0] mk(bit en, bit cmp, bit cpl, int thr, bit edg, int src, bit clr);
        logic [39:0] w = '0;
        w[12]    = en;
        w[15:13] = src[2:0];
        w[18]    = cmp;
        w[19]    = cpl;
        w[23:20] = thr[3:0];
        w[24]    = edg;
        w[31]    = clr;
        return w;
    endfunction

    task automatic chk(input string req, input logic [39:0] act, input logic [39:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input bit sel, input logic [39:0] d);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic ev(input int v);
        evt_cnt = v[3:0];
        @(negedge clk);
        evt_cnt = '0;
    endtask

    task automatic rd(input bit sel, output logic [39:0] v);
        rd_sel = sel;
        #1;
        v = rd_data;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_run++;
            $display("FAIL watchdog: actual hung expected done");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [39:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 R11
        rd(1'b1, v); chk("R1 counter", v, 40'd0);
        rd(1'b0, v); chk("R1 control", v, 40'd0);
        chk("R1 irq", {39'd0, ovf_irq}, 40'd0);

        // R2 hold while disabled
        ev(9); ev(9);
        rd(1'b1, v); chk("R2 disabled hold", v, 40'd0);

        // R3 raw: sum 0..15, complement and edge set but ignored
        wr(1'b1, 40'd0);
        wr(1'b0, mk(1, 0, 1, 3, 1, 0, 0));
        for (int k = 0; k < 16; k++) ev(k);
        rd(1'b1, v); chk("R3 raw sum", v, 40'd120);

        // R4 R5 level sweep over all thresholds and both senses
        for (int c = 0; c < 2; c++) begin
            for (int t = 0; t < 16; t++) begin
                wr(1'b0, 40'd0);
                wr(1'b1, 40'd0);
                wr(1'b0, mk(1, 1, c[0], t, 0, 0, 0));
                for (int k = 0; k < 16; k++) ev(k);
                rd(1'b1, v);
                if (c == 0) chk("R4 greater-than count", v, 40'(15 - t));
                else        chk("R5 le count", v, 40'(t + 1));
            end
        end

        // R6 edge sweep, ascending and alternating patterns
        for (int c = 0; c < 2; c++) begin
            for (int t = 0; t < 16; t++) begin
                wr(1'b0, 40'd0);
                wr(1'b1, 40'd0);
                wr(1'b0, mk(1, 1, c[0], t, 1, 0, 0));
                for (int k = 0; k < 16; k++) ev(k);
                rd(1'b1, v);
                chk("R6 edge ascending", v, (c == 0 && t == 15) ? 40'd0 : 40'd1);
                wr(1'b0, 40'd0);
                wr(1'b1, 40'd0);
                wr(1'b0, mk(1, 1, c[0], t, 1, 0, 0));
                for (int k = 0; k < 8; k++) begin ev(15); ev(0); end
                rd(1'b1, v);
                chk("R6 edge alternating", v,
                    (t == 15) ? ((c == 1) ? 40'd1 : 40'd0) : 40'd8);
            end
        end

        // R6 previous result cleared by a disabled cycle
        wr(1'b0, 40'd0);
        wr(1'b1, 40'd0);
        wr(1'b0, mk(1, 1, 0, 0, 1, 0, 0));
        ev(15);
        evt_cnt = 4'd15;
        wr(1'b0, mk(0, 1, 0, 0, 1, 0, 0));
        evt_cnt = 4'd0;
        ev(15);
        wr(1'b0, mk(1, 1, 0, 0, 1, 0, 0));
        ev(15);
        rd(1'b1, v); chk("R6 edge after disable", v, 40'd2);

        // R7 write beats increment
        wr(1'b0, mk(1, 0, 0, 0, 0, 0, 0));
        evt_cnt = 4'd7;
        wr(1'b1, 40'd100);
        evt_cnt = 4'd0;
        rd(1'b1, v); chk("R7 write priority", v, 40'd100);
        ev(7);
        rd(1'b1, v); chk("R7 count after load", v, 40'd107);

        // R8 overflow from preset negative value
        wr(1'b1, 40'hFF_FFFF_FFFB);
        ev(3);
        rd(1'b1, v); chk("R8 below wrap", v, 40'hFF_FFFF_FFFE);
        chk("R8 no irq yet", {39'd0, ovf_irq}, 40'd0);
        ev(3);
        rd(1'b1, v); chk("R8 wrapped", v, 40'd1);
        chk("R8 irq", {39'd0, ovf_irq}, 40'd1);
        ev(0); ev(0);
        rd(1'b0, v); chk("R8 sticky status", {39'd0, v[31]}, 40'd1);

        // R9 clear, then clear colliding with overflow
        wr(1'b0, mk(1, 0, 0, 0, 0, 0, 1));
        chk("R9 cleared", {39'd0, ovf_irq}, 40'd0);
        wr(1'b1, 40'hFF_FFFF_FFFF);
        evt_cnt = 4'd1;
        wr(1'b0, mk(1, 0, 0, 0, 0, 0, 1));
        evt_cnt = 4'd0;
        chk("R9 set wins", {39'd0, ovf_irq}, 40'd1);
        rd(1'b1, v); chk("R8 wrap to zero", v, 40'd0);
        wr(1'b0, mk(0, 0, 0, 0, 0, 0, 1));
        chk("R9 cleared again", {39'd0, ovf_irq}, 40'd0);

        // R10 R11 readback and reserved bits
        wr(1'b0, mk(0, 0, 0, 0, 0, 5, 0));
        rd(1'b0, v); chk("R10 source tag", v, 40'h0000_00_A000);
        wr(1'b0, 40'hFF_7FFF_FFFF);
        rd(1'b0, v); chk("R10 reserved zero", v, 40'h00_01FC_F000);
        wr(1'b0, 40'd0);
        wr(1'b1, 40'hA5_1234_5678);
        rd(1'b1, v); chk("R11 counter read 40b", v, 40'hA5_1234_5678);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule